// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives several pulse-width-modulated outputs from one source clock. Each channel has its own 32-bit control word, which is written and read over a plain register port. The word holds an enable flag, an arm flag that clears itself, an 8-bit tick prescaler, an 11-bit high-time count and a 10-bit period count. Every `pre+1` source cycles the prescaler makes one tick. A period is `div+1` ticks long, and the output stays high for the first `hi` ticks of every period.

Writing a control word only stages the values. The counts reach the running counters only when the arm flag is set. If the channel is running, the new counts are loaded at the next period boundary, so the current period is never cut short. If the channel is idle, they are loaded at once. After the load the arm flag reads back as 0. With the enable flag clear, the output is driven low and the counters stay at the start of a period.

Top module: `pwm_bank`

## Requirements
- R1: A read of channel `rd_addr` gives that channel's staged word on `rd_data` one cycle later. Bit 31 is enable, bit 30 is arm, bits 29:22 are pre, bits 20:10 are hi and bits 9:0 are div. Bit 21 always reads 0, whatever was written to it.
- R2: A write with bit 30 set arms the channel. If the channel is idle, the staged counts are loaded within two cycles. Once loaded, bit 30 reads 0.
- R3: While enabled, the output repeats with a period of exactly (pre+1)*(div+1) source cycles.
- R4: In each period the output is high for the first hi*(pre+1) cycles and low for the rest.
- R5: With hi = 0 the output stays low. With hi >= div+1 the output stays high.
- R6: One cycle after the edge that captures a write clearing bit 31, the output is 0 and it stays 0. When the channel is enabled again, it starts a fresh period: the output is 0 one cycle after the capturing edge and high (for hi > 0) two cycles after it.
- R7: A write with bit 30 clear changes the read-back word but leaves the running period and high time unchanged.
- R8: An arm received while a channel runs stays pending until the current period ends. That period completes with its old length, and the new counts apply from the next period.
- R9: Writes to one channel have no effect on any other channel's output.
- R10: After reset, every control word reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Channel selected by the write |
| wr_data | input | 32 | Control word to stage |
| rd_addr | input | 2 | Channel selected by the read |
| rd_data | output | 32 | Staged word of the channel read, registered |
| pwm_out | output | 4 | One registered output per channel |

## Verification
Two settings with different prescaler, period and high-time values are measured edge to edge. This tells a correct prescale product apart from an off-by-one in either counter, and a high time counted in ticks apart from one counted in source cycles. The high-time extremes (zero, exactly one period, and the field maximum) separate the constant-low and constant-high corners from normal duty. An arm that arrives in the middle of a long period, and a write made without arming, show the difference between a deferred commit, an immediate commit and no commit. Disable followed by re-enable, and writes to a neighbouring channel, check that the counters restart and that the channels are independent.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int DEF_CH     = 4;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_PRE_W  = 8;
  localparam int DEF_HI_W   = 11;
  localparam int DEF_DIV_W  = 10;

  typedef enum logic {ST_IDLE, ST_RUN} ch_state_e;
endpackage

// File: rtl/pwm_cfg_reg.sv
`timescale 1ns/1ps
module pwm_cfg_reg #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int HI_W   = 11,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              apply,
  output logic              en,
  output logic              pend,
  output logic [PRE_W-1:0]  pre,
  output logic [HI_W-1:0]   hi,
  output logic [DIV_W-1:0]  div,
  output logic [DATA_W-1:0] word
);
  localparam int EN_BIT  = DATA_W - 1;
  localparam int ARM_BIT = DATA_W - 2;
  localparam int PRE_LSB = ARM_BIT - PRE_W;
  localparam int HI_LSB  = DIV_W;
  localparam int GAP_LSB = HI_LSB + HI_W;
  localparam int GAP_W   = PRE_LSB - GAP_LSB;

  logic unused_gap;
  assign unused_gap = ^wdata[GAP_LSB +: GAP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      pend <= 1'b0;
      pre  <= '0;
      hi   <= '0;
      div  <= '0;
    end else if (wr) begin
      en   <= wdata[EN_BIT];
      pend <= wdata[ARM_BIT];
      pre  <= wdata[PRE_LSB +: PRE_W];
      hi   <= wdata[HI_LSB +: HI_W];
      div  <= wdata[0 +: DIV_W];
    end else if (apply) begin
      pend <= 1'b0;
    end
  end

  always_comb begin
    word                    = '0;
    word[EN_BIT]            = en;
    word[ARM_BIT]           = pend;
    word[PRE_LSB +: PRE_W]  = pre;
    word[HI_LSB +: HI_W]    = hi;
    word[0 +: DIV_W]        = div;
  end
endmodule

// File: rtl/pwm_chan_core.sv
`timescale 1ns/1ps
module pwm_chan_core
  import pwm_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int HI_W  = 11,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pend,
  input  logic [PRE_W-1:0] pre,
  input  logic [HI_W-1:0]  hi,
  input  logic [DIV_W-1:0] div,
  output logic             apply,
  output logic             running,
  output logic             wrap,
  output logic [PRE_W-1:0] act_pre,
  output logic [HI_W-1:0]  act_hi,
  output logic [DIV_W-1:0] act_div,
  output logic             pwm_o
);
  localparam int CMP_W = (HI_W > DIV_W) ? HI_W : DIV_W;

  ch_state_e        st_q;
  logic [PRE_W-1:0] pcnt;
  logic [DIV_W-1:0] tcnt;
  logic             tick;
  logic [CMP_W-1:0] tc_x, hi_x;

  assign running = (st_q == ST_RUN);
  assign tick    = (pcnt == act_pre);
  assign wrap    = running && tick && (tcnt == act_div);
  // commit a staged setting only when no period is in flight
  assign apply   = pend && (!running || wrap);
  assign tc_x    = CMP_W'(tcnt);
  assign hi_x    = CMP_W'(act_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pcnt    <= '0;
      tcnt    <= '0;
      act_pre <= '0;
      act_hi  <= '0;
      act_div <= '0;
      pwm_o   <= 1'b0;
    end else begin
      if (apply) begin
        act_pre <= pre;
        act_hi  <= hi;
        act_div <= div;
      end
      pwm_o <= en && running && (tc_x < hi_x);
      if (!en) begin
        st_q <= ST_IDLE;
        pcnt <= '0;
        tcnt <= '0;
      end else if (!running) begin
        st_q <= ST_RUN;
        pcnt <= '0;
        tcnt <= '0;
      end else if (tick) begin
        pcnt <= '0;
        tcnt <= (tcnt == act_div) ? '0 : tcnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = DEF_CH,
  parameter int DATA_W = DEF_DATA_W,
  parameter int PRE_W  = DEF_PRE_W,
  parameter int HI_W   = DEF_HI_W,
  parameter int DIV_W  = DEF_DIV_W,
  localparam int AW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ACT_W = PRE_W + HI_W + DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [DATA_W-1:0]             word_v [NUM_CH];
  logic [NUM_CH-1:0]             en_v, pend_v, run_v, wrap_v, apply_v;
  logic [NUM_CH-1:0][ACT_W-1:0]  act_v;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             wr_g;
    logic [PRE_W-1:0] pre_s, pre_a;
    logic [HI_W-1:0]  hi_s, hi_a;
    logic [DIV_W-1:0] div_s, div_a;

    assign wr_g = wr_en && (wr_addr == AW'(g));

    pwm_cfg_reg #(.DATA_W(DATA_W), .PRE_W(PRE_W), .HI_W(HI_W), .DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst(rst), .wr(wr_g), .wdata(wr_data), .apply(apply_v[g]),
      .en(en_v[g]), .pend(pend_v[g]), .pre(pre_s), .hi(hi_s), .div(div_s),
      .word(word_v[g])
    );

    pwm_chan_core #(.PRE_W(PRE_W), .HI_W(HI_W), .DIV_W(DIV_W)) u_core (
      .clk(clk), .rst(rst), .en(en_v[g]), .pend(pend_v[g]),
      .pre(pre_s), .hi(hi_s), .div(div_s),
      .apply(apply_v[g]), .running(run_v[g]), .wrap(wrap_v[g]),
      .act_pre(pre_a), .act_hi(hi_a), .act_div(div_a), .pwm_o(pwm_out[g])
    );

    assign act_v[g] = {pre_a, hi_a, div_a};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= word_v[rd_addr];
  end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 2,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int HI_W   = 11,
  parameter int DIV_W  = 10,
  localparam int ACT_W = PRE_W + HI_W + DIV_W
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            wr_en,
  input logic [AW-1:0]                   wr_addr,
  input logic [DATA_W-1:0]               rd_data,
  input logic [NUM_CH-1:0]               pwm_out,
  input logic [NUM_CH-1:0]               en_v,
  input logic [NUM_CH-1:0]               pend_v,
  input logic [NUM_CH-1:0]               run_v,
  input logic [NUM_CH-1:0]               wrap_v,
  input logic [NUM_CH-1:0][ACT_W-1:0]    act_v
);
  localparam int GAP_BIT = DIV_W + HI_W;

  assert_gap_zero_R1: assert property (@(posedge clk) disable iff (rst)
    rd_data[GAP_BIT] == 1'b0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(c));

    assert_off_low_R6: assert property (@(posedge clk) disable iff (rst)
      $past(!en_v[c]) |-> !pwm_out[c]);

    assert_idle_commit_R2: assert property (@(posedge clk) disable iff (rst)
      $past(pend_v[c] && !run_v[c] && !hit) |-> !pend_v[c]);

    assert_zero_hi_low_R5: assert property (@(posedge clk) disable iff (rst)
      $past(act_v[c][DIV_W +: HI_W] == '0) |-> !pwm_out[c]);

    assert_commit_boundary_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(act_v[c]) |-> $past(!run_v[c] || wrap_v[c]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH(NUM_CH), .AW(AW), .DATA_W(DATA_W),
  .PRE_W(PRE_W), .HI_W(HI_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_data(rd_data),
  .pwm_out(pwm_out), .en_v(en_v), .pend_v(pend_v), .run_v(run_v),
  .wrap_v(wrap_v), .act_v(act_v)
);

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] mk(bit en, bit arm, int pre, int hi, int dv);
    return {en, arm, 8'(pre), 1'b0, 11'(hi), 10'(dv)};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int ch, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 2'(ch);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int ch, int ep, int eh, string tag);
    int p = 0;
    int h = 0;
    int guard = 0;
    logic prev;
    bit found = 1'b0;
    prev = pwm_out[ch];
    while (!found && guard < 5000) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) found = 1'b1;
      prev = pwm_out[ch];
      guard++;
    end
    found = 1'b0;
    while (!found && p < 5000) begin
      if (pwm_out[ch]) h++;
      p++;
      prev = pwm_out[ch];
      @(negedge clk);
      if (!prev && pwm_out[ch]) found = 1'b1;
    end
    chk(p == ep, {tag, " period"}, 32'(p), 32'(ep));
    chk(h == eh, {tag, " high"}, 32'(h), 32'(eh));
  endtask

  task automatic hold(int ch, logic v, int n, string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== v) bad++;
    end
    chk(bad == 0, tag, 32'(bad), 32'(0));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwm_out == 4'b0, "R10 outputs low", 32'(pwm_out), 0);
    for (int c = 0; c < 4; c++) begin
      rd(c, d);
      chk(d == 0, "R10 word zero", d, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(2, mk(0, 0, 200, 1500, 700) | 32'h0020_0000);
    rd(2, d);
    chk(d == mk(0, 0, 200, 1500, 700), "R1 readback bit21 zero", d, mk(0, 0, 200, 1500, 700));
    hold(2, 1'b0, 20, "R6 disabled channel low");
    wr(2, mk(0, 1, 5, 5, 5));
    idle(3);
    rd(2, d);
    chk(d == mk(0, 0, 5, 5, 5), "R2 idle arm clears", d, mk(0, 0, 5, 5, 5));
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(0, mk(1, 1, 2, 2, 4));
    idle(3);
    rd(0, d);
    chk(d == mk(1, 0, 2, 2, 4), "R2 arm reads zero after load", d, mk(1, 0, 2, 2, 4));
    measure(0, 15, 6, "R3 R4 ch0 pre2 div4 hi2");
    wr(1, mk(1, 1, 0, 3, 9));
    idle(3);
    measure(1, 10, 3, "R3 R4 ch1 pre0 div9 hi3");
  endtask

  task automatic t_no_arm();
    logic [31:0] d;
    wr(1, mk(1, 0, 3, 1, 3));
    measure(1, 10, 3, "R7 unarmed write ignored");
    rd(1, d);
    chk(d == mk(1, 0, 3, 1, 3), "R7 staged word visible", d, mk(1, 0, 3, 1, 3));
  endtask

  task automatic t_extremes();
    wr(3, mk(1, 1, 1, 0, 5));
    idle(5);
    hold(3, 1'b0, 60, "R5 hi zero constant low");
    wr(3, mk(1, 1, 1, 6, 5));
    idle(30);
    hold(3, 1'b1, 60, "R5 hi div+1 constant high");
    wr(3, mk(1, 1, 1, 2047, 5));
    idle(30);
    hold(3, 1'b1, 60, "R5 hi max constant high");
    measure(1, 10, 3, "R9 ch1 unaffected by ch3");
  endtask

  task automatic t_deferred();
    int cnt = 0;
    logic prev;
    bit found = 1'b0;
    logic pend_seen = 1'b0;
    wr(0, mk(1, 1, 9, 4, 9));
    idle(250);
    measure(0, 100, 40, "R3 R4 ch0 pre9 div9 hi4");
    prev = pwm_out[0];
    while (!found && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (!prev && pwm_out[0]) found = 1'b1;
      prev = pwm_out[0];
    end
    cnt = 1;
    found = 1'b0;
    while (!found && cnt < 5000) begin
      @(negedge clk);
      if (cnt == 5) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = mk(1, 1, 1, 3, 4);
      end
      if (cnt == 6) begin
        wr_en = 1'b0; rd_addr = 2'd0;
      end
      if (cnt == 8) pend_seen = rd_data[30];
      if (!prev && pwm_out[0]) found = 1'b1;
      else cnt++;
      prev = pwm_out[0];
    end
    chk(pend_seen == 1'b1, "R8 arm pending mid period", 32'(pend_seen), 1);
    chk(cnt == 100, "R8 current period not cut", 32'(cnt), 100);
    measure(0, 10, 6, "R8 new counts after boundary");
  endtask

  task automatic t_disable();
    wr(0, mk(0, 0, 1, 3, 4));
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R6 low after disable", 32'(pwm_out[0]), 0);
    hold(0, 1'b0, 30, "R6 stays low");
    wr(0, mk(1, 0, 1, 3, 4));
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R6 restart first cycle low", 32'(pwm_out[0]), 0);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R6 restart pulse begins", 32'(pwm_out[0]), 1);
    measure(0, 10, 6, "R6 R3 after re-enable");
    measure(1, 10, 3, "R9 ch1 unaffected by ch0");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_basic();
    t_no_arm();
    t_extremes();
    t_deferred();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule